// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers sixteen interrupt sources into one request line to the processor. Sources with even numbers come from external pins, which are active low. Sources with odd numbers are internal, active-high level requests from logic on the same clock. Each external pin passes through a synchronizer. Software then chooses, per pin, whether a falling edge latches a pending flag or the pin acts as an active-low level. Internal sources are always level-sensitive.

Software uses a 32-bit register bus with four word registers and single-cycle transfers. The registers are an enable mask, a pending register that is cleared by writing ones, an edge-select register, and a read-only vector register. The vector register holds the number of the highest-priority source that is both pending and enabled. The interrupt handler reads the vector, services that source, and clears the pending flag if the source is edge-triggered.

Top module: `pvic_top`

## Requirements
- R1: Register index `bus_addr` selects 0 = enable mask, 1 = pending, 2 = edge select, 3 = vector. In the mask, pending and edge-select words, source n sits at bit 31−n, and bits 15:0 read as zero.
- R2: A mask write replaces the whole mask word. A 1 enables a source and a 0 disables it. A disabled source still shows in the pending word but does not raise `irq_o` or appear in the vector.
- R3: Writing the pending register with bit 31−n set clears only the latched flag of edge-mode source n. Zero bits leave every other flag unchanged.
- R4: A vector read returns the code in bits 31:26, with bits 25:0 zero. The code is the lowest-numbered source that is both pending and enabled.
- R5: When no source is both pending and enabled, the vector code is 15 and `irq_o` is low.
- R6: Edge-select bits are stored only for even sources, and odd positions read back as zero. An even source with its bit at 1 latches pending on a falling pin edge. The flag stays set after the pin returns high, until software clears it.
- R7: An even source with its edge-select bit at 0 is pending while its synchronized pin is low. A pending-register write cannot clear it while the pin stays low.
- R8: An odd source's pending flag equals its `int_req` input as registered at the previous clock edge. Pending-register writes have no effect on it.
- R9: A new pin level first sampled at clock edge k reaches the pending flag at edge k+2, in both edge and level mode.
- R10: When a falling edge sets an edge-mode flag in the same cycle that software writes a 1 to clear it, the flag stays set.
- R11: `irq_o` is high exactly when some source is both pending and enabled. Reset clears the mask, pending and edge-select registers and gives vector code 15.
- R12: Source 15 has the lowest priority and its vector code equals the idle code 15. In that case `irq_o` is high, which tells the two apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read, zero otherwise |
| ext_irq_n | input | 8 | External pins, active low; bit k is source 2k |
| int_req | input | 8 | Internal level requests, active high; bit k is source 2k+1 |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Two events can land in the same cycle: the falling edge that sets an edge-mode pending flag, and a software write that clears that flag. The bench first latches the flag with one pin pulse and lets the pin return high. It then drives the pin low again and times the clearing write so that it takes effect on exactly the edge where the synchronized fall reaches the flag. It checks that the flag reads back set, and that a later clear with no edge present does empty it.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

    localparam int PVIC_NUM_SRC     = 16;
    localparam int PVIC_BUS_W       = 32;
    localparam int PVIC_VEC_W       = 6;
    localparam int PVIC_IDLE_VEC    = 15;
    localparam int PVIC_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        RA_MASK = 2'd0,
        RA_PEND = 2'd1,
        RA_EDGE = 2'd2,
        RA_VEC  = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/pvic_sync.sv
module pvic_sync #(
    parameter int WIDTH   = 8,
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {(STAGES*WIDTH){RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/pvic_pending.sv
module pvic_pending #(
    parameter int NUM_SRC = 16,
    localparam int NUM_EXT = NUM_SRC / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_n_sync,
    input  logic [NUM_EXT-1:0] int_req,
    input  logic [NUM_EXT-1:0] edge_sel,
    input  logic [NUM_EXT-1:0] clr,
    output logic [NUM_SRC-1:0] pend
);

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_EXT-1:0] prev_n;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.prev_n = ext_n_sync;
        for (int k = 0; k < NUM_EXT; k++) begin
            // even source: external pin, edge or level
            if (edge_sel[k]) begin
                // a fresh fall wins over a clear in the same cycle
                st_d.pend[2*k] = (st_q.pend[2*k] & ~clr[k])
                               | (st_q.prev_n[k] & ~ext_n_sync[k]);
            end else begin
                st_d.pend[2*k] = ~ext_n_sync[k];
            end
            // odd source: internal level, follows the request
            st_d.pend[2*k+1] = int_req[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend   <= '0;
            st_q.prev_n <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

endmodule

// File: rtl/pvic_prio_enc.sv
module pvic_prio_enc #(
    parameter int N        = 16,
    parameter int VEC_W    = 6,
    parameter int IDLE_VEC = 15
) (
    input  logic [N-1:0]     act,
    output logic [VEC_W-1:0] code
);

    // lowest index has the highest priority: scan downward, last hit wins
    always_comb begin
        code = VEC_W'(IDLE_VEC);
        for (int i = N - 1; i >= 0; i--) begin
            if (act[i]) begin
                code = VEC_W'(i);
            end
        end
    end

endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
#(
    parameter int NUM_SRC     = PVIC_NUM_SRC,
    parameter int BUS_W       = PVIC_BUS_W,
    parameter int VEC_W       = PVIC_VEC_W,
    parameter int IDLE_VEC    = PVIC_IDLE_VEC,
    parameter int SYNC_STAGES = PVIC_SYNC_STAGES,
    localparam int NUM_EXT    = NUM_SRC / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [NUM_EXT-1:0] ext_irq_n,
    input  logic [NUM_EXT-1:0] int_req,
    output logic               irq_o
);

    localparam int PAD_W = BUS_W - NUM_SRC;

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [NUM_EXT-1:0] edge_ext;
    } regs_t;

    regs_t              regs_d, regs_q;
    logic [NUM_SRC-1:0] wr_bits;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] mask_cur;
    logic [NUM_SRC-1:0] act;
    logic [NUM_EXT-1:0] clr_ext;
    logic [NUM_EXT-1:0] ext_sync_n;
    logic [VEC_W-1:0]   vec_code;
    logic               wr_mask, wr_pend, wr_edge, rd_en;

    // bus word bit 31-n carries source n
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            wr_bits[i] = bus_wdata[BUS_W-1-i];
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            logic unused_pad;
            assign unused_pad = ^bus_wdata[PAD_W-1:0];
        end
    endgenerate

    assign wr_mask = bus_sel & bus_wr & (bus_addr == RA_MASK);
    assign wr_pend = bus_sel & bus_wr & (bus_addr == RA_PEND);
    assign wr_edge = bus_sel & bus_wr & (bus_addr == RA_EDGE);
    assign rd_en   = bus_sel & ~bus_wr;

    always_comb begin
        regs_d = regs_q;
        if (wr_mask) begin
            regs_d.mask = wr_bits;
        end
        if (wr_edge) begin
            for (int k = 0; k < NUM_EXT; k++) begin
                regs_d.edge_ext[k] = wr_bits[2*k];
            end
        end
        for (int k = 0; k < NUM_EXT; k++) begin
            clr_ext[k] = wr_pend & wr_bits[2*k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    pvic_sync #(
        .WIDTH   (NUM_EXT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_irq_n),
        .dout  (ext_sync_n)
    );

    pvic_pending #(
        .NUM_SRC (NUM_SRC)
    ) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_n_sync (ext_sync_n),
        .int_req    (int_req),
        .edge_sel   (regs_q.edge_ext),
        .clr        (clr_ext),
        .pend       (pend)
    );

    assign mask_cur = regs_q.mask;
    assign act      = pend & mask_cur;
    assign irq_o    = |act;

    pvic_prio_enc #(
        .N        (NUM_SRC),
        .VEC_W    (VEC_W),
        .IDLE_VEC (IDLE_VEC)
    ) u_enc (
        .act  (act),
        .code (vec_code)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (reg_addr_e'(bus_addr))
                RA_MASK: begin
                    for (int i = 0; i < NUM_SRC; i++) begin
                        bus_rdata[BUS_W-1-i] = regs_q.mask[i];
                    end
                end
                RA_PEND: begin
                    for (int i = 0; i < NUM_SRC; i++) begin
                        bus_rdata[BUS_W-1-i] = pend[i];
                    end
                end
                RA_EDGE: begin
                    for (int k = 0; k < NUM_EXT; k++) begin
                        bus_rdata[BUS_W-1-2*k] = regs_q.edge_ext[k];
                    end
                end
                RA_VEC: begin
                    bus_rdata[BUS_W-1 -: VEC_W] = vec_code;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pvic_chk.sv
module pvic_chk
    import pvic_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int BUS_W    = 32,
    parameter int VEC_W    = 6,
    parameter int IDLE_VEC = 15,
    localparam int NUM_EXT = NUM_SRC / 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [1:0]         bus_addr,
    input logic [BUS_W-1:0]   bus_rdata,
    input logic               irq_o,
    input logic [NUM_EXT-1:0] int_req,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] mask,
    input logic [VEC_W-1:0]   vec_code
);

    logic [NUM_EXT-1:0] pend_odd;
    logic [BUS_W-1:0]   odd_pos;
    logic [NUM_SRC-1:0] act;
    logic               code_hit;
    logic               lower_act;

    always_comb begin
        act       = pend & mask;
        odd_pos   = '0;
        code_hit  = 1'b0;
        lower_act = 1'b0;
        for (int k = 0; k < NUM_EXT; k++) begin
            pend_odd[k]            = pend[2*k+1];
            odd_pos[BUS_W-2-2*k]   = 1'b1;
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (VEC_W'(i) == vec_code) code_hit = act[i];
            if (VEC_W'(i) <  vec_code) lower_act = lower_act | act[i];
        end
    end

    // R5
    idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> vec_code == VEC_W'(IDLE_VEC));

    // R4
    prio_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (code_hit && !lower_act));

    // R4
    vec_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == RA_VEC) |-> bus_rdata[BUS_W-VEC_W-1:0] == '0);

    // R6
    edge_odd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == RA_EDGE) |-> (bus_rdata & odd_pos) == '0);

    // R8
    int_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend_odd == $past(int_req));

endmodule

bind pvic_top pvic_chk #(
    .NUM_SRC  (NUM_SRC),
    .BUS_W    (BUS_W),
    .VEC_W    (VEC_W),
    .IDLE_VEC (IDLE_VEC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .int_req   (int_req),
    .pend      (pend),
    .mask      (mask_cur),
    .vec_code  (vec_code)
);

// File: tb/pvic_top_tb.sv
`timescale 1ns/1ps
module pvic_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  ext_irq_n = 8'hFF;
    logic [7:0]  int_req = 8'h00;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pvic_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ext_irq_n (ext_irq_n),
        .int_req   (int_req),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic [31:0] mask;
        logic [7:0]  req;
        logic [5:0]  code;
        logic        irq;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t TBL [NVEC] = '{
        '{32'hFFFF0000, 8'h00, 6'd15, 1'b0},
        '{32'hFFFF0000, 8'h01, 6'd1,  1'b1},
        '{32'hFFFF0000, 8'h80, 6'd15, 1'b1},
        '{32'hFFFF0000, 8'h06, 6'd3,  1'b1},
        '{32'hEFFF0000, 8'h06, 6'd5,  1'b1},
        '{32'h00000000, 8'hFF, 6'd15, 1'b0},
        '{32'h00040000, 8'hFF, 6'd13, 1'b1},
        '{32'h01000000, 8'h0F, 6'd7,  1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_pin(input int k);
        @(negedge clk);
        ext_irq_n[k] = 1'b0;
        repeat (3) @(negedge clk);
        ext_irq_n[k] = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] req_to_pend(input logic [7:0] r);
        logic [31:0] w = '0;
        for (int k = 0; k < 8; k++) w[31-(2*k+1)] = r[k];
        return w;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        rd_reg(2'd0, d); check("R11 mask after reset", d, 32'h0);
        rd_reg(2'd1, d); check("R11 pending after reset", d, 32'h0);
        rd_reg(2'd2, d); check("R11 edge after reset", d, 32'h0);
        rd_reg(2'd3, d); check("R11 vector after reset", d, 32'h3C000000);
        check("R11 irq after reset", {31'b0, irq_o}, 32'h0);

        // R4 R5 R8 R12: table of internal-level patterns
        for (int v = 0; v < NVEC; v++) begin
            wr_reg(2'd0, TBL[v].mask);
            @(negedge clk);
            int_req = TBL[v].req;
            repeat (2) @(negedge clk);
            rd_reg(2'd3, d);
            check($sformatf("R4 vector row %0d", v), d, {TBL[v].code, 26'b0});
            check($sformatf("R11 irq row %0d", v), {31'b0, irq_o}, {31'b0, TBL[v].irq});
            rd_reg(2'd1, d);
            check($sformatf("R8 pending row %0d", v), d, req_to_pend(TBL[v].req));
        end
        @(negedge clk);
        int_req = 8'h00;

        // R6: odd edge bits dropped, falling edge latches
        wr_reg(2'd2, 32'hFFFFFFFF);
        rd_reg(2'd2, d); check("R6 edge readback", d, 32'hAAAA0000);
        wr_reg(2'd0, 32'hFFFF0000);
        pulse_pin(1);
        rd_reg(2'd1, d); check("R6 edge latched src2", d, 32'h20000000);
        rd_reg(2'd3, d); check("R4 vector src2", d, 32'h08000000);
        check("R11 irq src2", {31'b0, irq_o}, 32'h1);

        // R3: write-one-to-clear affects only selected flags
        wr_reg(2'd1, 32'h00000000);
        rd_reg(2'd1, d); check("R3 zero write keeps", d, 32'h20000000);
        pulse_pin(2);
        rd_reg(2'd1, d); check("R3 two latched", d, 32'h28000000);
        wr_reg(2'd1, 32'h20000000);
        rd_reg(2'd1, d); check("R3 clear src2 only", d, 32'h08000000);
        rd_reg(2'd3, d); check("R4 vector src4", d, 32'h10000000);
        wr_reg(2'd1, 32'h08000000);
        rd_reg(2'd1, d); check("R3 clear src4", d, 32'h0);
        rd_reg(2'd3, d); check("R5 idle vector", d, 32'h3C000000);
        check("R5 irq idle", {31'b0, irq_o}, 32'h0);

        // R9: synchronizer latency, level mode
        wr_reg(2'd2, 32'h0);
        @(negedge clk);
        ext_irq_n[0] = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        peek(2'd1, d); check("R9 not yet after two edges", d, 32'h0);
        @(posedge clk);
        @(negedge clk);
        peek(2'd1, d); check("R9 pending on third edge", d, 32'h80000000);

        // R7: level flag survives a clear while pin low
        wr_reg(2'd1, 32'h80000000);
        rd_reg(2'd1, d); check("R7 clear ignored while low", d, 32'h80000000);
        rd_reg(2'd3, d); check("R4 vector src0", d, 32'h00000000);
        @(negedge clk);
        ext_irq_n[0] = 1'b1;
        repeat (4) @(negedge clk);
        rd_reg(2'd1, d); check("R7 follows pin high", d, 32'h0);

        // R8: internal flag not cleared by software
        @(negedge clk);
        int_req = 8'h01;
        wr_reg(2'd1, 32'h40000000);
        rd_reg(2'd1, d); check("R8 clear ignored", d, 32'h40000000);
        @(negedge clk);
        int_req = 8'h00;
        repeat (2) @(negedge clk);
        rd_reg(2'd1, d); check("R8 drops with request", d, 32'h0);

        // R10: fall and clear in the same cycle
        wr_reg(2'd2, 32'h80000000);
        pulse_pin(0);
        rd_reg(2'd1, d); check("R10 first latch", d, 32'h80000000);
        @(negedge clk);
        ext_irq_n[0] = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h80000000;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        peek(2'd1, d); check("R10 set wins over clear", d, 32'h80000000);
        wr_reg(2'd1, 32'h80000000);
        rd_reg(2'd1, d); check("R10 plain clear", d, 32'h0);
        @(negedge clk);
        ext_irq_n[0] = 1'b1;
        repeat (4) @(negedge clk);

        // R2 R1: masked source pending but silent; whole-word mask write
        wr_reg(2'd2, 32'h0);
        wr_reg(2'd0, 32'h0);
        @(negedge clk);
        int_req = 8'h04;
        repeat (2) @(negedge clk);
        rd_reg(2'd1, d); check("R2 masked still pending", d, 32'h04000000);
        check("R2 masked no irq", {31'b0, irq_o}, 32'h0);
        rd_reg(2'd3, d); check("R2 masked vector idle", d, 32'h3C000000);
        wr_reg(2'd0, 32'hFFFFFFFF);
        rd_reg(2'd0, d); check("R1 mask low bits zero", d, 32'hFFFF0000);
        rd_reg(2'd3, d); check("R2 unmasked vector src5", d, 32'h14000000);
        check("R2 unmasked irq", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        int_req = 8'h00;
        repeat (2) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule